// File: doc/BRIEF.md
# Ping-Pong Character Strip Buffer

This block sits between a character-mode fetch engine and a dot shifter. It holds two small strips, each a few character columns wide, and the two swap roles. The fill strip takes writes from the fetch engine while the display strip is read out column by column by the shifter. Every column slot is a 16-bit cell. The upper byte is the attribute and the lower byte is the bitmap. Each byte has its own write enable, so attribute bursts and bitmap bursts can land in the same slots at different times without disturbing each other.

A second read port looks into the fill strip and returns only the attribute byte of a chosen column. This lets the fetch path extend a character code with an attribute bit while the bitmap bytes of the same strip are still arriving. When the shifter signals that the last pixel of the display strip has been rendered, the roles swap on the next clock edge. The block then emits a one-cycle swap pulse that tells the fetch engine to refill the strip that was just released.

Top module: `chstrip_pingpong`

## Requirements
- R1: The strip width `COLS` is 4, 8 or 16 columns, and columns 0 through `COLS-1` can all be written and read, including the highest one.
- R2: While `rst` is high at a clock edge, the following state results: `disp_sel` is 0 (strip 0 shows), `swap_req` is 0, and every byte of both strips is 0.
- R3: An attribute write (`wr_attr_en`=1) loads `wr_attr` into bits 15:8 of column `wr_col` of the fill strip at the clock edge. The bitmap byte of that slot is not changed.
- R4: A bitmap write (`wr_bmp_en`=1) loads `wr_bmp` into bits 7:0 of column `wr_col` of the fill strip. The attribute byte of that slot is not changed.
- R5: `disp_rd_pair` is combinational. It equals {attribute, bitmap} of column `disp_rd_col` of the display strip in the same cycle that the address is applied.
- R6: `fill_rd_attr` is combinational. It returns the attribute byte of column `fill_rd_col` of the fill strip, and it stays valid while a bitmap write to that strip is in progress.
- R7: A clock edge with `strip_done`=1 toggles `disp_sel`. The strip selected by `disp_sel` is the display strip and the other one is the fill strip. Without `strip_done`, `disp_sel` holds.
- R8: `swap_req` is high for exactly the one cycle that follows an edge with `strip_done`=1, and low otherwise.
- R9: A write made at the same edge as a swap goes to the strip that was the fill strip before the swap. That strip is the display strip afterwards.
- R10: Writes never change the contents of the display strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strip_done | input | 1 | Last pixel of the display strip rendered; swap at this edge |
| wr_attr_en | input | 1 | Attribute byte write enable |
| wr_bmp_en | input | 1 | Bitmap byte write enable |
| wr_col | input | $clog2(COLS) | Fill-strip column written |
| wr_attr | input | 8 | Attribute write data |
| wr_bmp | input | 8 | Bitmap write data |
| fill_rd_col | input | $clog2(COLS) | Column for the fill-side attribute read |
| fill_rd_attr | output | 8 | Attribute byte of the fill-strip column |
| disp_rd_col | input | $clog2(COLS) | Column for the display-side read |
| disp_rd_pair | output | 16 | {attribute, bitmap} of the display-strip column |
| disp_sel | output | 1 | Index of the strip currently on display |
| swap_req | output | 1 | One-cycle request to start fetching the next strip |

## Verification
The hardest case to reach from the ports is a write that coincides with a swap. The data must land in the strip that is leaving the fill role, and it can only be seen afterwards through the display port. The stimulus drives a combined attribute and bitmap write to the top column in the same cycle as `strip_done`, then reads that column on the display side. A second hard case is reading back an attribute through the fill port while a bitmap write to the same column is pending. The bench holds the write inputs and the fill address together and checks the attribute before the edge commits the write.

// File: rtl/chstrip_pkg.sv
package chstrip_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        byte_t attr;
        byte_t bmp;
    } cell_t;

    typedef enum logic {
        SIDE_0 = 1'b0,
        SIDE_1 = 1'b1
    } side_e;

    typedef struct packed {
        logic  attr_we;
        logic  bmp_we;
        byte_t attr;
        byte_t bmp;
    } lane_wr_t;

    function automatic bit cols_legal(int n);
        return (n == 4) || (n == 8) || (n == 16);
    endfunction

    function automatic side_e opposite(side_e s);
        return (s == SIDE_0) ? SIDE_1 : SIDE_0;
    endfunction

endpackage

// File: rtl/strip_role_ctl.sv
module strip_role_ctl
    import chstrip_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strip_done,
    output side_e disp_side,
    output logic  swap_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_side  <= SIDE_0;
            swap_pulse <= 1'b0;
        end else begin
            swap_pulse <= strip_done;
            if (strip_done) begin
                disp_side <= opposite(disp_side);
            end
        end
    end

endmodule

// File: rtl/strip_bank.sv
module strip_bank
    import chstrip_pkg::*;
#(
    parameter int COLS = 8,
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_fill,
    input  lane_wr_t      wr,
    input  logic [CW-1:0] wr_col,
    input  logic [CW-1:0] pair_col,
    output cell_t         pair_out,
    input  logic [CW-1:0] attr_col,
    output byte_t         attr_out
);

    cell_t cells [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic hit;
        assign hit = sel_fill && (wr_col == CW'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                cells[c] <= '0;
            end else begin
                if (hit && wr.attr_we) begin
                    cells[c].attr <= wr.attr;
                end
                if (hit && wr.bmp_we) begin
                    cells[c].bmp <= wr.bmp;
                end
            end
        end
    end

    always_comb begin
        pair_out = cells[pair_col];
        attr_out = cells[attr_col].attr;
    end

endmodule

// File: rtl/chstrip_pingpong.sv
module chstrip_pingpong
    import chstrip_pkg::*;
#(
    parameter int COLS = 8,
    localparam int CW = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strip_done,
    input  logic          wr_attr_en,
    input  logic          wr_bmp_en,
    input  logic [CW-1:0] wr_col,
    input  logic [7:0]    wr_attr,
    input  logic [7:0]    wr_bmp,
    input  logic [CW-1:0] fill_rd_col,
    output logic [7:0]    fill_rd_attr,
    input  logic [CW-1:0] disp_rd_col,
    output logic [15:0]   disp_rd_pair,
    output logic          disp_sel,
    output logic          swap_req
);

    localparam int NBANK = 2;

    side_e    disp_side;
    side_e    fill_side;
    lane_wr_t lane;
    cell_t    pair_rd [NBANK];
    byte_t    attr_rd [NBANK];

    strip_role_ctl u_role (
        .clk        (clk),
        .rst        (rst),
        .strip_done (strip_done),
        .disp_side  (disp_side),
        .swap_pulse (swap_req)
    );

    assign fill_side = opposite(disp_side);

    always_comb begin
        lane.attr_we = wr_attr_en;
        lane.bmp_we  = wr_bmp_en;
        lane.attr    = wr_attr;
        lane.bmp     = wr_bmp;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        strip_bank #(.COLS(COLS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .sel_fill (fill_side == side_e'(b)),
            .wr       (lane),
            .wr_col   (wr_col),
            .pair_col (disp_rd_col),
            .pair_out (pair_rd[b]),
            .attr_col (fill_rd_col),
            .attr_out (attr_rd[b])
        );
    end

    always_comb begin
        disp_rd_pair = pair_rd[disp_side];
        fill_rd_attr = attr_rd[fill_side];
        disp_sel     = disp_side;
    end

endmodule

// File: rtl/chstrip_pingpong_chk.sv
module chstrip_pingpong_chk
    import chstrip_pkg::*;
#(
    parameter int COLS = 8,
    localparam int CW = $clog2(COLS)
) (
    input logic          clk,
    input logic          rst,
    input logic          strip_done,
    input logic          wr_attr_en,
    input logic          wr_bmp_en,
    input logic [CW-1:0] wr_col,
    input logic [7:0]    wr_attr,
    input logic [7:0]    wr_bmp,
    input logic [CW-1:0] fill_rd_col,
    input logic [7:0]    fill_rd_attr,
    input logic [CW-1:0] disp_rd_col,
    input logic [15:0]   disp_rd_pair,
    input logic          disp_sel,
    input logic          swap_req
);

    initial begin
        AST_COLS_LEGAL: assert (cols_legal(COLS)); // R1
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (disp_sel == 1'b0 && !swap_req)); // R2

    AST_ATTR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_attr_en && !strip_done) |=>
            (fill_rd_col != $past(wr_col) || fill_rd_attr == $past(wr_attr))); // R3

    AST_SEL_FLIPS: assert property (@(posedge clk) disable iff (rst)
        strip_done |=> (disp_sel != $past(disp_sel))); // R7

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !strip_done |=> $stable(disp_sel)); // R7

    AST_SWAP_RAISED: assert property (@(posedge clk) disable iff (rst)
        strip_done |=> swap_req); // R8

    AST_SWAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !strip_done |=> !swap_req); // R8

    AST_SWAP_WRITE_OLD_FILL: assert property (@(posedge clk) disable iff (rst)
        (strip_done && wr_bmp_en) |=>
            (disp_rd_col != $past(wr_col) || disp_rd_pair[7:0] == $past(wr_bmp))); // R9

    AST_DISP_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        !strip_done |=>
            (disp_rd_col != $past(disp_rd_col) || $stable(disp_rd_pair))); // R10

endmodule

bind chstrip_pingpong chstrip_pingpong_chk #(.COLS(COLS)) u_chk (.*);

// File: tb/test_chstrip_pingpong.sv
`timescale 1ns/1ps
module test_chstrip_pingpong;

    localparam int COLS = 8;
    localparam int CW   = $clog2(COLS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strip_done = 1'b0;
    logic          wr_attr_en = 1'b0;
    logic          wr_bmp_en  = 1'b0;
    logic [CW-1:0] wr_col = '0;
    logic [7:0]    wr_attr = '0;
    logic [7:0]    wr_bmp  = '0;
    logic [CW-1:0] fill_rd_col = '0;
    logic [7:0]    fill_rd_attr;
    logic [CW-1:0] disp_rd_col = '0;
    logic [15:0]   disp_rd_pair;
    logic          disp_sel;
    logic          swap_req;

    chstrip_pingpong #(.COLS(COLS)) i_chstrip_pingpong (.*);

    always #2.5 clk = ~clk;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] exp;
    } item_t;

    item_t       q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [15:0] mdl [2][COLS];
    int          msel = 0;

    // monitor: compares queued expectations against the ports
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t       it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = disp_rd_pair;
                1:       act = {8'h00, fill_rd_attr};
                2:       act = {15'b0, disp_sel};
                default: act = {15'b0, swap_req};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d: actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(string r, int k, logic [15:0] e);
        item_t it;
        it.req = r; it.kind = k; it.exp = e;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic chk_disp(string r, int col);
        disp_rd_col = CW'(col);
        push(r, 0, mdl[msel][col]);
    endtask

    task automatic chk_fill(string r, int col);
        fill_rd_col = CW'(col);
        push(r, 1, {8'h00, mdl[1-msel][col][15:8]});
    endtask

    task automatic clear_model();
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < COLS; c++) mdl[s][c] = '0;
        msel = 0;
    endtask

    // driver: one write / swap cycle, model updated at the edge
    task automatic step(bit a, bit b, int col, logic [7:0] ad, logic [7:0] bd, bit done);
        wr_attr_en = a; wr_bmp_en = b; wr_col = CW'(col);
        wr_attr = ad; wr_bmp = bd; strip_done = done;
        @(posedge clk);
        if (a) mdl[1-msel][col][15:8] = ad;
        if (b) mdl[1-msel][col][7:0]  = bd;
        if (done) msel = 1 - msel;
        #1;
        wr_attr_en = 0; wr_bmp_en = 0; strip_done = 0;
        push("R8", 3, {15'b0, done});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        push("R2", 2, 16'd0);
        push("R2", 3, 16'd0);
        for (int c = 0; c < COLS; c++) begin
            chk_disp("R2", c);
            chk_fill("R2", c);
        end

        // attribute lane into fill strip (strip 1)
        for (int c = 0; c < COLS; c++) step(1, 0, c, 8'h10 + 8'(c), 8'hFF, 0);
        for (int c = 0; c < COLS; c++) begin
            chk_fill("R3", c);
            chk_disp("R10", c);
        end

        // bitmap lane with concurrent fill-side attribute read
        for (int c = 0; c < COLS; c++) begin
            fill_rd_col = CW'(c);
            wr_bmp_en = 1; wr_col = CW'(c); wr_bmp = 8'hA0 + 8'(c); wr_attr = 8'hEE;
            push("R6", 1, {8'h00, mdl[1-msel][c][15:8]});
            @(posedge clk);
            mdl[1-msel][c][7:0] = 8'hA0 + 8'(c);
            #1 wr_bmp_en = 0;
        end
        chk_fill("R4", 3);

        // attribute overwrite keeps bitmap
        step(1, 0, 2, 8'h55, 8'h00, 0);
        chk_disp("R10", 2);

        // swap
        step(0, 0, 0, 8'h00, 8'h00, 1);
        push("R7", 2, 16'd1);
        @(posedge clk); #1;
        push("R8", 3, 16'd0);
        for (int c = 0; c < COLS; c++) chk_disp("R5", c);
        chk_disp("R4", 2);
        chk_fill("R7", 0);

        // write in the swap cycle lands in old fill strip, top column
        step(1, 1, COLS - 1, 8'hC3, 8'h3C, 1);
        push("R7", 2, 16'd0);
        chk_disp("R9", COLS - 1);
        chk_disp("R1", COLS - 1);
        chk_fill("R1", COLS - 1);

        // hold without strip_done
        repeat (4) step(0, 1, 1, 8'h00, 8'h77, 0);
        push("R7", 2, 16'd0);
        chk_fill("R6", 1);
        chk_disp("R10", 1);

        // reset again
        rst = 1;
        @(posedge clk); #1;
        rst = 0;
        clear_model();
        push("R2", 2, 16'd0);
        for (int c = 0; c < COLS; c++) begin
            chk_disp("R2", c);
            chk_fill("R2", c);
        end

        if (!finished) begin
            finished = 1;
            summary();
        end
    end

endmodule